// File: doc/BRIEF.md
# Port Pin Change Detector

This block watches the upper slice of an input port, bits 7 down to 4 of an 8-bit port by default, and sets a sticky change flag when any watched pin differs from a stored reference. A port-read strobe loads the watched pins into that reference. The pin inputs are assumed to be synchronized to `clk` before they reach this block.

Once a change is seen, a mismatch condition is latched and keeps setting the flag every cycle. It ends only after a port read followed by one further instruction-cycle strobe. Until then a software clear write has no effect. The flag is set whatever the enable bit holds, so software can poll it. The interrupt output is the flag gated by the enable bit.

The sequencer has three states:
- `ST_QUIET`: no condition is latched.
- `ST_CHANGED`: a mismatch has been seen.
- `ST_RDWAIT`: the port has been read and the block is waiting for the next instruction-cycle strobe.

Its transitions are:
- QUIET→CHANGED on a mismatch.
- CHANGED→RDWAIT on a port read.
- RDWAIT→QUIET on an instruction-cycle strobe with no mismatch.
- RDWAIT→CHANGED on an instruction-cycle strobe while a mismatch is present.
- Every other case holds the state. A strobe taken in CHANGED is ignored, even when it comes in the same cycle as the read.

Top module: `pcd_top`

## Requirements
- R1: Reset clears the flag, the interrupt, the enable bit and the reference, and puts the sequencer in ST_QUIET.
- R2: Pins below bit 4 (`pin_in[3:0]`) never take part in the compare, and changing them alone never sets the flag.
- R3: When any of `pin_in[7:4]` differs from the reference at a clock edge, `flag` is 1 after that edge, whatever the enable bit holds.
- R4: A cycle with `port_rd`=1 loads `pin_in[7:4]` into the reference at that edge.
- R5: While the sequencer is in ST_CHANGED or ST_RDWAIT, a `flag_clr` write leaves `flag` at 1.
- R6: In ST_RDWAIT, an `icyc` strobe in a cycle after the read cycle returns the sequencer to ST_QUIET when there is no mismatch. A `flag_clr` after that clears `flag` at the next edge.
- R7: If the watched pins differ from the reference when that `icyc` strobe arrives, the sequencer goes back to ST_CHANGED and the flag stays uncleared.
- R8: A mismatch in the same cycle as `flag_clr` wins, and `flag` stays 1.
- R9: `en_wr`=1 loads `en_din` into the enable bit (`en_bit`). `irq` is 1 exactly when `flag` and `en_bit` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| icyc | input | 1 | Instruction-cycle strobe, one clock wide |
| port_rd | input | 1 | Port read strobe; loads the reference |
| pin_in | input | PORT_W | Synchronized port pins |
| flag_clr | input | 1 | Software clear write for the flag |
| en_wr | input | 1 | Write strobe for the enable bit |
| en_din | input | 1 | Value written to the enable bit |
| flag | output | 1 | Sticky change flag |
| irq | output | 1 | Flag gated by the enable bit |
| en_bit | output | 1 | Current enable bit |

## Verification
The assertions assume that:
- `pin_in` is already synchronous to `clk` and free of X.
- Each strobe (`icyc`, `port_rd`, `flag_clr`, `en_wr`) is a clean level sampled at one edge.

The stimulus changes every input only at the falling edge. It holds the pins steady across each rising edge. It never leaves an input undriven after reset is released. The directed sequences place the read, the strobe and the clear in chosen cycles, so that the latched condition is seen ending and being re-entered.

// File: rtl/pcd_pkg.sv
`timescale 1ns/1ps
package pcd_pkg;
    typedef enum logic [1:0] {
        ST_QUIET   = 2'd0,
        ST_CHANGED = 2'd1,
        ST_RDWAIT  = 2'd2
    } pcd_state_e;
endpackage

// File: rtl/pcd_compare.sv
`timescale 1ns/1ps
module pcd_compare #(
    parameter int PORT_W   = 8,
    parameter int WATCH_LO = 4,
    localparam int WATCH_W = PORT_W - WATCH_LO
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               port_rd,
    input  logic [PORT_W-1:0]  pin_in,
    output logic [WATCH_W-1:0] ref_q,
    output logic               mismatch
);
    logic [WATCH_W-1:0] diff_bits;

    for (genvar i = 0; i < WATCH_W; i++) begin : g_bit
        // reference flop for one watched pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ref_q[i] <= 1'b0;
            else if (port_rd)
                ref_q[i] <= pin_in[WATCH_LO + i];
        end
        assign diff_bits[i] = pin_in[WATCH_LO + i] ^ ref_q[i];
    end

    assign mismatch = |diff_bits;
endmodule

// File: rtl/pcd_seq.sv
`timescale 1ns/1ps
module pcd_seq
    import pcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mismatch,
    input  logic       port_rd,
    input  logic       icyc,
    input  logic       flag_clr,
    output pcd_state_e state,
    output logic       cond_active,
    output logic       flag
);
    pcd_state_e state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_QUIET;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_QUIET: begin
                if (mismatch)
                    state_nx = ST_CHANGED;
            end
            ST_CHANGED: begin
                if (port_rd)
                    state_nx = ST_RDWAIT;
            end
            ST_RDWAIT: begin
                if (icyc)
                    state_nx = mismatch ? ST_CHANGED : ST_QUIET;
            end
            default: state_nx = ST_QUIET;
        endcase
    end

    assign cond_active = (state != ST_QUIET);

    // flag output register: set beats clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (cond_active || mismatch)
            flag <= 1'b1;
        else if (flag_clr)
            flag <= 1'b0;
    end
endmodule

// File: rtl/pcd_enable.sv
`timescale 1ns/1ps
module pcd_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic en_din,
    output logic en_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (en_wr)
            en_q <= en_din;
    end
endmodule

// File: rtl/pcd_top.sv
`timescale 1ns/1ps
module pcd_top
    import pcd_pkg::*;
#(
    parameter int PORT_W   = 8,
    parameter int WATCH_LO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              icyc,
    input  logic              port_rd,
    input  logic [PORT_W-1:0] pin_in,
    input  logic              flag_clr,
    input  logic              en_wr,
    input  logic              en_din,
    output logic              flag,
    output logic              irq,
    output logic              en_bit
);
    localparam int WATCH_W = PORT_W - WATCH_LO;

    logic [WATCH_W-1:0] ref_q;
    logic               mismatch;
    logic               cond_active;
    pcd_state_e         state;

    pcd_compare #(.PORT_W(PORT_W), .WATCH_LO(WATCH_LO)) u_cmp (
        .clk(clk), .rst_n(rst_n), .port_rd(port_rd), .pin_in(pin_in),
        .ref_q(ref_q), .mismatch(mismatch)
    );

    pcd_seq u_seq (
        .clk(clk), .rst_n(rst_n), .mismatch(mismatch), .port_rd(port_rd),
        .icyc(icyc), .flag_clr(flag_clr), .state(state),
        .cond_active(cond_active), .flag(flag)
    );

    pcd_enable u_en (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_din(en_din), .en_q(en_bit)
    );

    assign irq = flag & en_bit;
endmodule

// File: rtl/pcd_checker.sv
`timescale 1ns/1ps
module pcd_checker #(
    parameter int PORT_W   = 8,
    parameter int WATCH_LO = 4,
    localparam int WATCH_W = PORT_W - WATCH_LO
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PORT_W-1:0]  pin_in,
    input logic               port_rd,
    input logic               flag_clr,
    input logic               flag,
    input logic               irq,
    input logic               en_bit,
    input logic               mismatch,
    input logic               cond_active,
    input logic [WATCH_W-1:0] ref_q
);
    assert_set_on_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> flag);

    assert_ref_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd |=> (ref_q == $past(pin_in[PORT_W-1:WATCH_LO])));

    assert_clear_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_active && flag_clr) |=> flag);

    assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !cond_active && !mismatch) |=> !flag);

    assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mismatch && !cond_active && !flag) |=> !flag);

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (en_bit && flag));
endmodule

bind pcd_top pcd_checker #(.PORT_W(PORT_W), .WATCH_LO(WATCH_LO)) u_chk (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .port_rd(port_rd),
    .flag_clr(flag_clr), .flag(flag), .irq(irq), .en_bit(en_bit),
    .mismatch(mismatch), .cond_active(cond_active), .ref_q(ref_q)
);

// File: tb/sim_pcd_top.sv
`timescale 1ns/1ps
module sim_pcd_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       icyc = 1'b0, port_rd = 1'b0, flag_clr = 1'b0, en_wr = 1'b0, en_din = 1'b0;
    logic [7:0] pin_in = 8'h00;
    logic       flag, irq, en_bit;
    int total = 0, bad = 0;

    always #4 clk = ~clk;

    pcd_top u0 (
        .clk(clk), .rst_n(rst_n), .icyc(icyc), .port_rd(port_rd), .pin_in(pin_in),
        .flag_clr(flag_clr), .en_wr(en_wr), .en_din(en_din),
        .flag(flag), .irq(irq), .en_bit(en_bit)
    );

    typedef struct packed {
        logic [7:0] pins;
        logic rd, ic, clr, ew, ed;
        logic ef, ei;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{8'h0F,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd2}, // R2 low bits only
        '{8'h05,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'd2}, // R2
        '{8'h05,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b0,1'b0, 4'd9}, // R9 enable on
        '{8'h15,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1, 4'd3}, // R3 bit4 changes
        '{8'h15,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b1, 4'd5}, // R5 clear blocked
        '{8'h15,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1, 4'd4}, // R4 read
        '{8'h15,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b1, 4'd5}, // R5 clear in wait
        '{8'h15,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1, 4'd6}, // R6 strobe ends cond
        '{8'h15,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b0,1'b0, 4'd6}, // R6 clear works
        '{8'h15,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0,1'b0, 4'd9}, // R9 enable off
        '{8'h95,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 4'd3}, // R3 flag without enable
        '{8'h95,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b1,1'b1, 4'd9}, // R9 enable on
        '{8'h95,1'b1,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1, 4'd6}, // R6 strobe with read ignored
        '{8'h85,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1, 4'd7}, // R7 mismatch at strobe
        '{8'h85,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b1, 4'd7}, // R7 still changed
        '{8'h85,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,1'b1, 4'd4}, // R4 read again
        '{8'h85,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,1'b1, 4'd6}, // R6 quiet
        '{8'h95,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1,1'b1, 4'd8}  // R8 set beats clear
    };

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] p, input logic rd, input logic ic,
                         input logic clr, input logic ew, input logic ed);
        @(negedge clk);
        pin_in = p; port_rd = rd; icyc = ic; flag_clr = clr; en_wr = ew; en_din = ed;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #800000;
        total++; bad++;
        $display("FAIL watchdog R0 actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 flag in reset", flag, 1'b0);
        check("R1 irq in reset", irq, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 enable after reset", en_bit, 1'b0);

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k].pins, VEC[k].rd, VEC[k].ic, VEC[k].clr, VEC[k].ew, VEC[k].ed);
            check($sformatf("R%0d vec%0d flag", VEC[k].req, k), flag, VEC[k].ef);
            check($sformatf("R%0d vec%0d irq", VEC[k].req, k), irq, VEC[k].ei);
        end

        // R1: reset in the middle of an active condition
        @(negedge clk) rst_n = 1'b0;
        pin_in = 8'h00; port_rd = 0; icyc = 0; flag_clr = 0; en_wr = 0;
        #1;
        check("R1 flag mid reset", flag, 1'b0);
        check("R1 enable mid reset", en_bit, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 quiet after reset", flag, 1'b0);

        // R2: walk each low bit alone
        for (int b = 0; b < 4; b++) begin
            drive(8'h01 << b, 0, 0, 0, 0, 0);
            check($sformatf("R2 low bit %0d", b), flag, 1'b0);
        end

        // R4: reference follows the read value
        drive(8'hA0, 0, 0, 0, 0, 0);
        drive(8'hA0, 1, 0, 0, 0, 0);
        drive(8'hA0, 0, 1, 0, 0, 0);
        drive(8'hA3, 0, 0, 1, 0, 0);
        check("R4 cleared with new reference", flag, 1'b0);
        drive(8'hA3, 0, 0, 0, 0, 0);
        check("R4 no change vs reference", flag, 1'b0);
        drive(8'hB3, 0, 0, 0, 0, 0);
        check("R3 change vs reference", flag, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule